// File: doc/BRIEF.md
# Hierarchical Petri Net Logic Controller

This block is a synchronous logic controller that executes one fixed, interpreted hierarchical Petri net. Each place holds at most one token, so the controller state is a marking register with one bit per place. The top level has four places: an idle place, a run macroplace, a timed cool-down place and a lock place. The run macroplace contains a subnet with two concurrent branches, A and B. The branches finish on terminal places, and the macroplace can be left normally only after both of them have finished.

External Boolean inputs feed the transition conditions. Place-driven outputs stay high while their place is marked. Transition actions produce one-cycle pulses. The lock place drives an internal signal that a transition condition reads back. A strong stop condition preempts the subnet at any time. The macroplace keeps a history of its subnet, so that a run which was interrupted resumes where it stopped. A run that had fully completed starts again from the beginning.

All transitions that are enabled on the current marking fire together on one clock edge.

Top module: `hpn_ctrl`

## Requirements
- R1: After reset the marking holds only the idle place. The saved subnet history equals the subnet's initial marking (A-start and B-start). The timer, the action pulses and the safeness flag are all zero.
- R2: Bit positions of `mark_o`: 0 idle, 1 run, 2 cool, 3 lock, 4 A-start, 5 A-end, 6 B-start, 7 B-end. A firing transition removes the token from each of its ordinary input places and marks each of its output places.
- R3: Inhibitor and enabling arcs. `start_i` moves idle to run only while lock is unmarked. The B step (B-start to B-end on `go_b_i`) also needs A-end to be marked, and A-end keeps its token when B steps.
- R4: The lock place drives an internal signal. While lock is marked, the A step (A-start to A-end on `go_a_i`) is blocked in that same cycle.
- R5: Entering run loads a subnet marking. Run is left normally (run to cool, with a pulse on `done_o`) only when A-end and B-end are both marked and `stop_i` is low. Leaving run clears every subnet place, and subnet places are never marked while run is unmarked.
- R6: `stop_i` while run is marked is a strong condition. It moves run to idle at once, whatever the subnet state, clears the subnet and pulses `quit_o`. A subnet step requested in the same cycle is suppressed and produces no pulse.
- R7: History. On re-entry the subnet gets back the marking it had just before run was last left. If that saved marking was exactly {A-end, B-end}, the initial marking {A-start, B-start} is loaded instead.
- R8: The cool place has a minimum activity time of `COOL_TIME` cycles. Its output transition (cool to idle) is held for `COOL_TIME` cycles after cool is marked and fires on the next edge, so `cool_o` is high for `COOL_TIME`+1 cycles.
- R9: `run_o`, `work_a_o`, `work_b_o` and `cool_o` follow the run, A-start, B-start and cool places. `step_a_o`, `done_o` and `quit_o` each go high for exactly the one cycle after their transition fires.
- R10: `safe_err_o` is set when a firing would mark a place that stays marked, or when two firings mark the same place. Once set it stays high until reset. `lock_set_i` while lock is marked is such a violation.
- R11: Transitions that are enabled at the same time fire on the same clock edge, for example the lock set together with an A step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Condition of idle to run |
| stop_i | input | 1 | Strong condition that preempts run |
| go_a_i | input | 1 | Condition of the A step |
| go_b_i | input | 1 | Condition of the B step |
| lock_set_i | input | 1 | Marks the lock place |
| lock_clr_i | input | 1 | Removes the lock token |
| mark_o | output | 8 | Current marking (bit map as in R2) |
| run_o | output | 1 | Run macroplace marked |
| work_a_o | output | 1 | A-start place marked |
| work_b_o | output | 1 | B-start place marked |
| cool_o | output | 1 | Cool place marked |
| step_a_o | output | 1 | One-cycle action of the A step |
| done_o | output | 1 | One-cycle action of normal run exit |
| quit_o | output | 1 | One-cycle action of preemptive exit |
| safe_err_o | output | 1 | Sticky safeness violation flag |

## Verification
The preemptive exit from the macroplace and a step inside its subnet can both fall in one cycle. The bench provokes this by raising `stop_i` and `go_a_i` together while the subnet is in its initial marking. It then requires three things. The marking must fall to idle only, `step_a_o` must stay low, and the next entry must restore the marking from before that edge, not the marking with A-end set. The lock set firing in the same edge as an A step is judged the same way.

// File: rtl/hpn_pkg.sv
package hpn_pkg;

  localparam int NP = 8;
  localparam int NT = 8;

  // place indices (also the bit positions of the marking)
  localparam int P_IDLE = 0;
  localparam int P_RUN  = 1;
  localparam int P_COOL = 2;
  localparam int P_LOCK = 3;
  localparam int P_A0   = 4;
  localparam int P_A1   = 5;
  localparam int P_B0   = 6;
  localparam int P_B1   = 7;

  // transition indices
  localparam int T_ENTER = 0;
  localparam int T_DONE  = 1;
  localparam int T_ABORT = 2;
  localparam int T_COOL  = 3;
  localparam int T_STEPA = 4;
  localparam int T_STEPB = 5;
  localparam int T_LSET  = 6;
  localparam int T_LCLR  = 7;

  typedef logic [NP-1:0] mark_t;
  typedef logic [NT-1:0] tvec_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic go_a;
    logic go_b;
    logic lock_set;
    logic lock_clr;
  } ext_t;

  function automatic mark_t pl(input int p);
    pl = mark_t'(1) << p;
  endfunction

  localparam mark_t SUB_MASK = mark_t'(8'hF0);
  localparam mark_t SUB_INIT = mark_t'(8'h50);
  localparam mark_t SUB_TERM = mark_t'(8'hA0);
  localparam mark_t TOP_INIT = mark_t'(8'h01);

  // ordinary (consuming) input places
  function automatic mark_t ord_in(input int t);
    case (t)
      T_ENTER:         ord_in = pl(P_IDLE);
      T_DONE, T_ABORT: ord_in = pl(P_RUN);
      T_COOL:          ord_in = pl(P_COOL);
      T_STEPA:         ord_in = pl(P_A0);
      T_STEPB:         ord_in = pl(P_B0);
      T_LCLR:          ord_in = pl(P_LOCK);
      default:         ord_in = '0;
    endcase
  endfunction

  // enabling (read-only) input places
  function automatic mark_t en_in(input int t);
    en_in = (t == T_STEPB) ? pl(P_A1) : '0;
  endfunction

  // inhibitor places
  function automatic mark_t inh_in(input int t);
    inh_in = (t == T_ENTER) ? pl(P_LOCK) : '0;
  endfunction

  // output places
  function automatic mark_t out_pl(input int t);
    case (t)
      T_ENTER:         out_pl = pl(P_RUN);
      T_DONE:          out_pl = pl(P_COOL);
      T_ABORT, T_COOL: out_pl = pl(P_IDLE);
      T_STEPA:         out_pl = pl(P_A1);
      T_STEPB:         out_pl = pl(P_B1);
      T_LSET:          out_pl = pl(P_LOCK);
      default:         out_pl = '0;
    endcase
  endfunction

  // transitions whose lowest ancestor is the run macroplace
  function automatic logic in_sub(input int t);
    in_sub = (t == T_STEPA) || (t == T_STEPB);
  endfunction

  function automatic logic leaves_run(input int t);
    mark_t o;
    o = ord_in(t);
    leaves_run = o[P_RUN];
  endfunction

  function automatic logic enters_run(input int t);
    mark_t o;
    o = out_pl(t);
    enters_run = o[P_RUN];
  endfunction

  // structural part: arcs of every kind
  function automatic logic place_ok(input int t, input mark_t m);
    mark_t need;
    need = ord_in(t) | en_in(t);
    place_ok = ((m & need) == need) && ((m & inh_in(t)) == '0);
  endfunction

  // weak part besides cond: macro completion and activity time
  function automatic logic weak_ok(input int t, input mark_t m, input mark_t ripe);
    mark_t o;
    logic  macro_fin;
    o = ord_in(t);
    macro_fin = !o[P_RUN] || ((m & SUB_TERM) == SUB_TERM);
    weak_ok = macro_fin && ((o & ~ripe) == '0);
  endfunction

  // subnet marking to load on entry from the saved history
  function automatic mark_t resume(input mark_t saved);
    resume = ((saved & SUB_MASK) == SUB_TERM) ? SUB_INIT : (saved & SUB_MASK);
  endfunction

  function automatic int place_time(input int p, input int cool);
    place_time = (p == P_COOL) ? cool : 0;
  endfunction

endpackage

// File: rtl/hpn_guard.sv
module hpn_guard
  import hpn_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mark_t mark_i,
  input  mark_t ripe_i,
  input  ext_t  ext_i,
  output tvec_t fire_o
);

  logic  lk_int;
  tvec_t cond_v;
  tvec_t abort_v;
  tvec_t arm;
  logic  leave_run;
  mark_t seen;
  logic  clash;

  // transition labels; lk_int is the lock place's internal signal
  always_comb begin
    lk_int           = mark_i[P_LOCK];
    cond_v           = '0;
    abort_v          = '0;
    cond_v[T_ENTER]  = ext_i.start;
    cond_v[T_DONE]   = ~ext_i.stop;
    abort_v[T_ABORT] = ext_i.stop;
    cond_v[T_COOL]   = 1'b1;
    cond_v[T_STEPA]  = ext_i.go_a & ~lk_int;
    cond_v[T_STEPB]  = ext_i.go_b;
    cond_v[T_LSET]   = ext_i.lock_set;
    cond_v[T_LCLR]   = ext_i.lock_clr;
  end

  always_comb begin
    arm       = '0;
    leave_run = 1'b0;
    for (int t = 0; t < NT; t++) begin
      arm[t] = place_ok(t, mark_i) &&
               ((cond_v[t] && weak_ok(t, mark_i, ripe_i)) || abort_v[t]);
      if (!in_sub(t) && arm[t] && leaves_run(t)) leave_run = 1'b1;
    end
    // subnet transitions need their macroplace and lose to its exit
    for (int t = 0; t < NT; t++) begin
      fire_o[t] = in_sub(t) ? (arm[t] && mark_i[P_RUN] && !leave_run) : arm[t];
    end
  end

  // determinism: no ordinary input place taken by two firings
  always_comb begin
    seen  = '0;
    clash = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (fire_o[t]) begin
        if ((seen & ord_in(t)) != '0) clash = 1'b1;
        seen = seen | ord_in(t);
      end
    end
  end

  p_single_taker_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clash);

endmodule

// File: rtl/hpn_timers.sv
module hpn_timers
  import hpn_pkg::*;
#(
  parameter int COOL_TIME = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mark_t mark_i,
  input  mark_t nxt_i,
  output mark_t ripe_o
);

  localparam int TW = (COOL_TIME < 2) ? 1 : $clog2(COOL_TIME + 1);

  for (genvar i = 0; i < NP; i++) begin : g_pl
    localparam int TI = place_time(i, COOL_TIME);
    if (TI > 0) begin : g_timed
      logic [TW-1:0] cnt_q;

      always_ff @(posedge clk_i) begin
        if (!rst_ni)                    cnt_q <= '0;
        else if (nxt_i[i] && !mark_i[i]) cnt_q <= TW'(TI);
        else if (!nxt_i[i])             cnt_q <= '0;
        else if (cnt_q != '0)           cnt_q <= cnt_q - 1'b1;
      end

      assign ripe_o[i] = (cnt_q == '0);

      p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mark_i[i] && !ripe_o[i]) |=> mark_i[i]);
      p_fresh_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nxt_i[i] && !mark_i[i]) |=> !ripe_o[i]);
    end else begin : g_free
      assign ripe_o[i] = 1'b1;
    end
  end

endmodule

// File: rtl/hpn_marking.sv
module hpn_marking
  import hpn_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  tvec_t fire_i,
  output mark_t mark_o,
  output mark_t nxt_o,
  output logic  err_o
);

  mark_t mark_q;
  mark_t hist_q;
  logic  err_q;
  mark_t cons;
  mark_t prod;
  mark_t clr;
  mark_t restore;
  mark_t keep;
  logic  dup;
  logic  enter;
  logic  leave;
  logic  viol;

  always_comb begin
    cons  = '0;
    prod  = '0;
    dup   = 1'b0;
    enter = 1'b0;
    leave = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (fire_i[t]) begin
        cons = cons | ord_in(t);
        if ((prod & out_pl(t)) != '0) dup = 1'b1;
        prod = prod | out_pl(t);
        if (leaves_run(t)) leave = 1'b1;
        if (enters_run(t)) enter = 1'b1;
      end
    end
    clr     = leave ? SUB_MASK : '0;
    restore = enter ? resume(hist_q) : '0;
    keep    = mark_q & ~cons & ~clr;
    viol    = dup || ((prod & keep) != '0) || ((restore & keep) != '0);
    nxt_o   = keep | prod | restore;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mark_q <= TOP_INIT;
      hist_q <= SUB_INIT;
      err_q  <= 1'b0;
    end else begin
      mark_q <= nxt_o;
      if (leave) hist_q <= mark_q & SUB_MASK;
      if (viol)  err_q  <= 1'b1;
    end
  end

  assign mark_o = mark_q;
  assign err_o  = err_q;

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_preempt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i[T_ABORT] |=> ((mark_q & SUB_MASK) == '0) && !mark_q[P_RUN] && mark_q[P_IDLE]);
  p_resume_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i[T_ENTER] |=> ((mark_q & SUB_MASK) != SUB_TERM) && ((mark_q & SUB_MASK) != '0));
  p_nested_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mark_q & SUB_MASK) != '0) |-> mark_q[P_RUN]);

endmodule

// File: rtl/hpn_ctrl.sv
module hpn_ctrl
  import hpn_pkg::*;
#(
  parameter int COOL_TIME = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       go_a_i,
  input  logic       go_b_i,
  input  logic       lock_set_i,
  input  logic       lock_clr_i,
  output logic [7:0] mark_o,
  output logic       run_o,
  output logic       work_a_o,
  output logic       work_b_o,
  output logic       cool_o,
  output logic       step_a_o,
  output logic       done_o,
  output logic       quit_o,
  output logic       safe_err_o
);

  ext_t  ext;
  mark_t mark;
  mark_t nxt;
  mark_t ripe;
  tvec_t fire;
  logic  step_a_q;
  logic  done_q;
  logic  quit_q;

  assign ext = '{start: start_i, stop: stop_i, go_a: go_a_i, go_b: go_b_i,
                 lock_set: lock_set_i, lock_clr: lock_clr_i};

  hpn_guard u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mark_i (mark),
    .ripe_i (ripe),
    .ext_i  (ext),
    .fire_o (fire)
  );

  hpn_marking u_marking (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .mark_o (mark),
    .nxt_o  (nxt),
    .err_o  (safe_err_o)
  );

  hpn_timers #(.COOL_TIME(COOL_TIME)) u_timers (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mark_i (mark),
    .nxt_i  (nxt),
    .ripe_o (ripe)
  );

  // transition actions: one cycle, aligned with the new marking
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      step_a_q <= 1'b0;
      done_q   <= 1'b0;
      quit_q   <= 1'b0;
    end else begin
      step_a_q <= fire[T_STEPA];
      done_q   <= fire[T_DONE];
      quit_q   <= fire[T_ABORT];
    end
  end

  assign mark_o   = mark;
  assign run_o    = mark[P_RUN];
  assign work_a_o = mark[P_A0];
  assign work_b_o = mark[P_B0];
  assign cool_o   = mark[P_COOL];
  assign step_a_o = step_a_q;
  assign done_o   = done_q;
  assign quit_o   = quit_q;

  p_done_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cool_o && !run_o);
  p_quit_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quit_o |-> mark_o[P_IDLE] && !run_o);
  p_one_action_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({done_o, quit_o}) <= 1);

endmodule

// File: tb/hpn_ctrl_tb.sv
module hpn_ctrl_tb;

  localparam int N = 5;
  localparam logic [3:0] H_INIT = 4'b0101;
  localparam logic [3:0] H_TERM = 4'b1010;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, go_a_i = 0, go_b_i = 0, lock_set_i = 0, lock_clr_i = 0;
  logic [7:0] mark_o;
  logic run_o, work_a_o, work_b_o, cool_o, step_a_o, done_o, quit_o, safe_err_o;

  int total = 0;
  int bad = 0;

  // reference model state
  logic [7:0] em;
  logic [3:0] eh;
  int         etm;
  logic       eerr, ea, ed, eq;

  always #4 clk = ~clk;

  hpn_ctrl #(.COOL_TIME(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .go_a_i(go_a_i), .go_b_i(go_b_i), .lock_set_i(lock_set_i), .lock_clr_i(lock_clr_i),
    .mark_o(mark_o), .run_o(run_o), .work_a_o(work_a_o), .work_b_o(work_b_o),
    .cool_o(cool_o), .step_a_o(step_a_o), .done_o(done_o), .quit_o(quit_o),
    .safe_err_o(safe_err_o)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic compare_all();
    check("R2 marking", mark_o, em);
    check("R9 place outputs", {4'd0, cool_o, work_b_o, work_a_o, run_o},
          {4'd0, em[2], em[6], em[4], em[1]});
    check("R9 action pulses", {5'd0, quit_o, done_o, step_a_o}, {5'd0, eq, ed, ea});
    check("R10 safeness flag", {7'd0, safe_err_o}, {7'd0, eerr});
  endtask

  // behavioural next state of the net from the requirements
  task automatic model(input bit st, sp, ga, gb, ls, lc);
    logic idle, run, cool, lock, a0, a1, b0, b1;
    logic fe, fd, fq, fc, fa, fb, fl, fu, ex;
    logic [7:0] n;
    {b1, b0, a1, a0, lock, cool, run, idle} = em;
    fe = idle && !lock && st;
    fd = run && a1 && b1 && !sp;
    fq = run && sp;
    fc = cool && (etm == 0);
    ex = fd || fq;
    fa = run && !ex && a0 && ga && !lock;
    fb = run && !ex && b0 && a1 && gb;
    fl = ls;
    fu = lock && lc;
    if (fl && lock && !fu) eerr = 1;
    if (fd && cool && !fc) eerr = 1;
    if ((fq || fc) && idle && !fe) eerr = 1;
    if (fq && fc) eerr = 1;
    if (fe && run && !ex) eerr = 1;
    n = em;
    n[0] = (idle && !fe) || fq || fc;
    n[1] = (run && !ex) || fe;
    n[2] = (cool && !fc) || fd;
    n[3] = (lock && !fu) || fl;
    if (ex) begin
      eh = em[7:4];
      n[7:4] = 4'b0000;
    end else if (fe) begin
      n[7:4] = (eh == H_TERM) ? H_INIT : eh;
    end else begin
      if (fa) begin n[4] = 0; n[5] = 1; end
      if (fb) begin n[6] = 0; n[7] = 1; end
    end
    if (fd) etm = N;
    else if (!n[2]) etm = 0;
    else if (etm > 0) etm = etm - 1;
    ea = fa; ed = fd; eq = fq;
    em = n;
  endtask

  task automatic step(input bit st, sp, ga, gb, ls, lc);
    start_i = st; stop_i = sp; go_a_i = ga; go_b_i = gb;
    lock_set_i = ls; lock_clr_i = lc;
    model(st, sp, ga, gb, ls, lc);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_step();
    step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    em = 8'h01; eh = H_INIT; etm = 0; eerr = 0; ea = 0; ed = 0; eq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    compare_all();
    check("R1 reset marking", mark_o, 8'h01);

    // inhibitor arc from lock
    step(0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0);
    check("R3 inhibitor blocks entry", mark_o, 8'h09);
    step(0, 0, 0, 0, 0, 1);

    // entry from the initial history
    step(1, 0, 0, 0, 0, 0);
    check("R5 entry loads initial subnet", mark_o, 8'h52);
    step(0, 0, 0, 1, 0, 0);
    check("R3 enabling arc not satisfied", mark_o, 8'h52);
    step(0, 0, 1, 0, 1, 0);
    check("R11 lock set and A step together", mark_o, 8'h6A);
    check("R9 step pulse", {7'd0, step_a_o}, 8'h01);
    step(0, 0, 0, 1, 0, 0);
    check("R3 enabling arc keeps A-end", mark_o, 8'hAA);
    idle_step();
    check("R5 normal exit after both terminals", mark_o, 8'h0C);
    check("R5 done pulse", {7'd0, done_o}, 8'h01);

    // minimum activity time
    for (int k = 0; k < N; k++) begin
      idle_step();
      check("R8 cool held", {7'd0, cool_o}, 8'h01);
    end
    idle_step();
    check("R8 cool released", mark_o, 8'h09);
    step(0, 0, 0, 0, 0, 1);

    // internal signal from lock blocks the A step
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 0, 0);
    check("R4 lock signal blocks A step", mark_o, 8'h5A);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 0);
    check("R2 A step consumes A-start", mark_o, 8'h62);

    // preemption mid-run, then resume with history
    step(0, 1, 0, 0, 0, 0);
    check("R6 abort to idle", mark_o, 8'h01);
    check("R6 quit pulse", {7'd0, quit_o}, 8'h01);
    step(1, 0, 0, 0, 0, 0);
    check("R7 history restored", mark_o, 8'h62);
    step(0, 0, 0, 1, 0, 0);
    idle_step();
    check("R5 exit to cool", mark_o, 8'h04);
    for (int k = 0; k <= N; k++) idle_step();
    check("R8 back to idle", mark_o, 8'h01);
    step(1, 0, 0, 0, 0, 0);
    check("R7 terminal history gives initial", mark_o, 8'h52);

    // abort and subnet step in the same cycle
    step(0, 1, 1, 0, 0, 0);
    check("R6 abort wins over step", mark_o, 8'h01);
    check("R6 no step pulse", {7'd0, step_a_o}, 8'h00);
    step(1, 0, 0, 0, 0, 0);
    check("R6 saved pre-edge subnet", mark_o, 8'h52);
    step(0, 1, 0, 0, 0, 0);

    // deliberate double marking
    step(0, 0, 0, 0, 1, 0);
    check("R10 no error yet", {7'd0, safe_err_o}, 8'h00);
    step(0, 0, 0, 0, 1, 0);
    check("R10 double mark flagged", {7'd0, safe_err_o}, 8'h01);
    idle_step();
    check("R10 flag sticky", {7'd0, safe_err_o}, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule